// File: doc/BRIEF.md
# Two-Wire Register Slave with Downstream Proxy

This block is a slave on a two-wire serial bus (I2C-like). It gives a host byte-wide access to a register space that is split in two. A sub-address with its top bit set selects a small bank of local registers held inside the block. A sub-address with its top bit clear is forwarded, through a request/response proxy port, to a downstream device that holds its own registers. Each bus transaction carries exactly one data byte. There are no bursts and no clock stretching.

A write goes START, device address with R/W=0, sub-address, data byte, STOP. A read goes START, device address with R/W=0, sub-address, repeated START, device address with R/W=1, one byte from the slave, NACK from the host, STOP. Local registers answer at once. A downstream read only posts a fetch, so the host must issue a second read to collect the value. The slave refuses the second read's address phase (no acknowledge) while that fetch is still running, and the host retries until it is acknowledged.

The proxy request port uses valid/ready. Once `px_req_valid` is raised, it and the request fields hold until a cycle in which `px_req_ready` is high. At most one request is outstanding. The response is a one-cycle `px_rsp_valid` pulse with no ready, and it must come only while a request is outstanding. The bus pins are the oversampled `scl_i` and `sda_i`, plus an open-drain pull-down enable `sda_oe`.

Top module: `i2cpx_regslave`

## Requirements
- R1: After reset, `sda_oe` is 0, `px_req_valid` is 0, and every local register reads 00h.
- R2: A write transaction to sub-address 80h+i, where i < NREG, is acknowledged after the address byte, the sub-address byte and the data byte. Register i then holds the data byte.
- R3: A read transaction to sub-address 80h+i returns register i in that same transaction, MSB first. After the 8th data bit the slave releases SDA for the host's acknowledge slot, and SDA stays released after STOP.
- R4: When the 7-bit device address (bits 7:1 of the first byte) differs from DEV_ADDR, the slave gives no acknowledge and leaves SDA released. The rest of the transaction changes no register and posts no proxy request.
- R5: A write with a sub-address in 00h–7Fh posts one proxy request with write=1, addr equal to sub-address bits 6:0 and wdata equal to the data byte. Sub-addresses 80h–FFh never post a proxy request.
- R6: The data acknowledge of a downstream write is given only if the proxy response arrives before SCL falls at the end of the 8th data bit. Otherwise the byte is NACKed, but the posted request still reaches the downstream device.
- R7: A read of sub-address 00h–7Fh when no fetched value for that sub-address is buffered is acknowledged and posts one proxy request with write=0 and addr equal to sub-address bits 6:0. The byte returned in that transaction has no meaning.
- R8: While a proxy operation is outstanding, the address phase with R/W=1 of a downstream read is NACKed. Once the fetch has finished, a read of the same sub-address is acknowledged and returns the fetched value. That read consumes the buffer, so the next read of that sub-address posts a new fetch.
- R9: A START or STOP seen in the middle of a byte aborts the transaction without changing any local register and without posting a proxy request.
- R10: Sub-addresses 80h+NREG to FFh are acknowledged. Writes to them are dropped and reads of them return 00h.
- R11: The slave changes `sda_oe` only while SCL is low.
- R12: A raised `px_req_valid` and the request fields hold until `px_req_ready` is seen high. No new request is posted while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| px_req_valid | output | 1 | Proxy request valid |
| px_req_ready | input | 1 | Proxy request accepted this cycle when high with valid |
| px_req_write | output | 1 | 1 for a downstream write, 0 for a fetch |
| px_req_addr | output | 7 | Downstream register address |
| px_req_wdata | output | 8 | Downstream write data |
| px_rsp_valid | input | 1 | One-cycle completion pulse for the outstanding request |
| px_rsp_rdata | input | 8 | Fetched data, taken with px_rsp_valid on a fetch |

## Verification
The bench builds the block with its defaults: DEV_ADDR 2Ah, NREG 16 and a two-stage synchronizer. The bus runs at 20 system clocks per SCL period. With NREG at 16, the random local sub-addresses in 80h–93h reach both the populated bank and the empty range above it. The short SCL half-period gives a write acknowledge window of roughly ten clocks, so a proxy latency of a few cycles is acknowledged and one of 60 is not. A fetch latency of 1500 clocks outlasts a whole read transaction, which exposes the NACK-and-retry path.

// File: rtl/i2cpx_pkg.sv
package i2cpx_pkg;
  // protocol phase of the slave
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_SUB  = 3'd2,
    ST_WDAT = 3'd3,
    ST_TX   = 3'd4
  } st_e;

  localparam int BYTE_W = 8;
  localparam int PXA_W  = 7;
endpackage

// File: rtl/i2cpx_linemon.sv
module i2cpx_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cpx_locregs.sv
module i2cpx_locregs #(
  parameter int NREG = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] sub,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic       in_range;
  logic [7:0] rd_arr [NREG];

  assign in_range = ({1'b0, sub[6:0]} < NREG_B);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'h00;
      else if (we && in_range && (sub[IDX_W-1:0] == IDX_W'(g))) q <= wdata;
    end
    assign rd_arr[g] = q;
  end

  assign rdata = in_range ? rd_arr[sub[IDX_W-1:0]] : 8'h00;

  // R2
  loc_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> sub[7]) else $error("local write with a proxied sub-address");
endmodule

// File: rtl/i2cpx_proxy.sv
module i2cpx_proxy (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_post,
  input  logic       wr_post,
  input  logic       consume,
  input  logic [6:0] post_addr,
  input  logic [7:0] post_data,
  output logic       req_valid,
  input  logic       req_ready,
  output logic       req_write,
  output logic [6:0] req_addr,
  output logic [7:0] req_wdata,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_rdata,
  output logic       busy,
  output logic       buf_valid,
  output logic [6:0] buf_addr,
  output logic [7:0] buf_data
);
  logic pend_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      busy      <= 1'b0;
      pend_rd   <= 1'b0;
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
    end else begin
      if ((rd_post || wr_post) && !busy) begin
        req_valid <= 1'b1;
        req_write <= wr_post;
        req_addr  <= post_addr;
        req_wdata <= post_data;
        busy      <= 1'b1;
        pend_rd   <= rd_post;
        buf_valid <= 1'b0;
      end else begin
        if (req_valid && req_ready) req_valid <= 1'b0;
        if (rsp_valid && busy) begin
          busy <= 1'b0;
          if (pend_rd) begin
            buf_valid <= 1'b1;
            buf_addr  <= req_addr;
            buf_data  <= rsp_rdata;
          end
        end
        if (consume) buf_valid <= 1'b0;
      end
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)))
    else $error("request dropped or changed before acceptance");

  // R12
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_post || wr_post) |-> !busy) else $error("post while a request is outstanding");

  // R7
  rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy) else $error("response without outstanding request");
endmodule

// File: rtl/i2cpx_ctrl.sv
module i2cpx_ctrl
  import i2cpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] loc_rdata,
  input  logic       px_busy,
  input  logic       px_buf_valid,
  input  logic [6:0] px_buf_addr,
  input  logic [7:0] px_buf_data,
  output logic       sda_oe,
  output logic [7:0] sub_q,
  output logic [7:0] wbyte_q,
  output logic       reg_we,
  output logic       wr_post,
  output logic       rd_post,
  output logic       consume
);
  st_e        st;
  logic [3:0] cnt;
  logic [6:0] sh;
  logic       ack_on, ack_val, rw_q, wr_posted;
  logic [7:0] tx_sh;
  logic [7:0] rx_byte;
  logic       ack_now, buf_hit;

  assign rx_byte = {sh, sda_s};
  assign buf_hit = px_buf_valid && (px_buf_addr == sub_q[6:0]);

  // a proxied write is acknowledged only if its completion is already in
  always_comb begin
    ack_now = ack_val;
    if (st == ST_WDAT && !sub_q[7]) ack_now = wr_posted && !px_busy && !wr_post;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      ack_on    <= 1'b0;
      ack_val   <= 1'b0;
      rw_q      <= 1'b0;
      wr_posted <= 1'b0;
      tx_sh     <= '0;
      sda_oe    <= 1'b0;
      sub_q     <= '0;
      wbyte_q   <= '0;
      reg_we    <= 1'b0;
      wr_post   <= 1'b0;
      rd_post   <= 1'b0;
      consume   <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      wr_post <= 1'b0;
      rd_post <= 1'b0;
      consume <= 1'b0;
      if (start_det) begin
        st        <= ST_DEV;
        cnt       <= '0;
        ack_on    <= 1'b0;
        sda_oe    <= 1'b0;
        wr_posted <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else if (st == ST_TX) begin
        if (scl_rise && cnt != 4'd8) cnt <= cnt + 4'd1;
        if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            sda_oe <= ~tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise && cnt != 4'd8) begin
          sh  <= {sh[5:0], sda_s};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            case (st)
              ST_DEV: begin
                if (rx_byte[7:1] != DEV_ADDR) begin
                  st <= ST_IDLE;
                end else begin
                  rw_q    <= rx_byte[0];
                  ack_val <= 1'b1;
                  if (rx_byte[0]) begin
                    if (sub_q[7]) tx_sh <= loc_rdata;
                    else if (px_busy) ack_val <= 1'b0;
                    else begin
                      tx_sh <= px_buf_data;
                      if (buf_hit) consume <= 1'b1;
                      else rd_post <= 1'b1;
                    end
                  end
                end
              end
              ST_SUB: begin
                sub_q   <= rx_byte;
                ack_val <= 1'b1;
              end
              ST_WDAT: begin
                wbyte_q <= rx_byte;
                ack_val <= 1'b1;
                if (sub_q[7]) reg_we <= 1'b1;
                else if (!px_busy) begin
                  wr_post   <= 1'b1;
                  wr_posted <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        if (scl_fall && cnt == 4'd8) begin
          if (!ack_on) begin
            ack_on <= 1'b1;
            sda_oe <= ack_now;
          end else begin
            ack_on <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (st)
              ST_DEV: begin
                if (!ack_val) st <= ST_IDLE;
                else if (rw_q) begin
                  st     <= ST_TX;
                  sda_oe <= ~tx_sh[7];
                  tx_sh  <= {tx_sh[6:0], 1'b0};
                end else st <= ST_SUB;
              end
              ST_SUB:  st <= ST_WDAT;
              default: st <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R11
  sda_lowphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)) else $error("SDA changed while SCL high");

  // R5
  proxy_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_post || rd_post) |-> !sub_q[7]) else $error("proxy post for a local sub-address");

  // R8
  pend_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_post || consume) |-> !px_busy) else $error("read served while fetch pending");
endmodule

// File: rtl/i2cpx_regslave.sv
module i2cpx_regslave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NREG        = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       px_req_valid,
  input  logic       px_req_ready,
  output logic       px_req_write,
  output logic [6:0] px_req_addr,
  output logic [7:0] px_req_wdata,
  input  logic       px_rsp_valid,
  input  logic [7:0] px_rsp_rdata
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] loc_rdata, sub_q, wbyte_q;
  logic       reg_we, wr_post, rd_post, consume;
  logic       px_busy, px_buf_valid;
  logic [6:0] px_buf_addr;
  logic [7:0] px_buf_data;

  i2cpx_linemon #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cpx_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .loc_rdata(loc_rdata), .px_busy(px_busy), .px_buf_valid(px_buf_valid),
    .px_buf_addr(px_buf_addr), .px_buf_data(px_buf_data),
    .sda_oe(sda_oe), .sub_q(sub_q), .wbyte_q(wbyte_q), .reg_we(reg_we),
    .wr_post(wr_post), .rd_post(rd_post), .consume(consume)
  );

  i2cpx_locregs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sub(sub_q), .wdata(wbyte_q), .rdata(loc_rdata)
  );

  i2cpx_proxy u_px (
    .clk(clk), .rst_n(rst_n), .rd_post(rd_post), .wr_post(wr_post), .consume(consume),
    .post_addr(sub_q[6:0]), .post_data(wbyte_q),
    .req_valid(px_req_valid), .req_ready(px_req_ready), .req_write(px_req_write),
    .req_addr(px_req_addr), .req_wdata(px_req_wdata),
    .rsp_valid(px_rsp_valid), .rsp_rdata(px_rsp_rdata),
    .busy(px_busy), .buf_valid(px_buf_valid), .buf_addr(px_buf_addr), .buf_data(px_buf_data)
  );
endmodule

// File: tb/i2cpx_regslave_tb.sv
`timescale 1ns/1ps
module i2cpx_regslave_tb_top;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int NREG = 16;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic px_req_valid, px_req_write;
  logic px_req_ready = 1'b1;
  logic [6:0] px_req_addr;
  logic [7:0] px_req_wdata;
  logic px_rsp_valid = 1'b0;
  logic [7:0] px_rsp_rdata = 8'h00;
  wire sda_line = ~(m_sda_low | sda_oe);

  always #5 clk = ~clk;

  i2cpx_regslave #(.DEV_ADDR(DEV), .NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .px_req_valid(px_req_valid), .px_req_ready(px_req_ready), .px_req_write(px_req_write),
    .px_req_addr(px_req_addr), .px_req_wdata(px_req_wdata),
    .px_rsp_valid(px_rsp_valid), .px_rsp_rdata(px_rsp_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;
  logic [7:0] lmod [NREG];
  logic [7:0] pmem [128];
  int n_req = 0;
  logic last_w;
  logic [6:0] last_a;
  logic [7:0] last_d;
  int px_lat = 3;
  bit rdy_rand = 0;
  int cd = 0;
  logic [7:0] rsp_hold;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] exp_loc(input logic [7:0] s);
    int i = int'(s[6:0]);
    return (i < NREG) ? lmod[i] : 8'h00;
  endfunction

  // downstream device model, driven away from the active edge
  initial begin
    for (int i = 0; i < 128; i++) pmem[i] = 8'(i * 7 + 3);
    forever begin
      @(negedge clk);
      px_rsp_valid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          px_rsp_valid = 1'b1;
          px_rsp_rdata = rsp_hold;
        end
      end
      px_req_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      if (px_req_valid && px_req_ready) begin
        n_req++;
        last_w = px_req_write;
        last_a = px_req_addr;
        last_d = px_req_wdata;
        if (px_req_write) pmem[px_req_addr] = px_req_wdata;
        rsp_hold = pmem[px_req_addr];
        cd = px_lat;
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 0; m_scl = 1; wt(H);
    m_sda_low = 1; wt(H);
    m_scl = 0;
  endtask

  task automatic bus_rstart();
    wt(2); m_sda_low = 0; wt(H);
    m_scl = 1; wt(H);
    m_sda_low = 1; wt(H);
    m_scl = 0;
  endtask

  task automatic bus_stop();
    wt(2); m_sda_low = 1; wt(H);
    m_scl = 1; wt(H);
    m_sda_low = 0; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wt(2); m_sda_low = ~b[i]; wt(H);
      m_scl = 1; wt(H);
      m_scl = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    wt(2); m_sda_low = 0; wt(H);
    m_scl = 1; wt(H / 2);
    ack = (sda_line == 1'b0);
    wt(H / 2);
    m_scl = 0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wt(H); m_scl = 1; wt(H / 2);
      b = {b[6:0], sda_line};
      wt(H / 2); m_scl = 0;
    end
    wt(2); m_sda_low = 0; wt(H);
    m_scl = 1; wt(H);
    m_scl = 0;
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] sub, input logic [7:0] d,
                        output bit a1, output bit a2, output bit a3);
    bus_start();
    send_byte({dev, 1'b0}, a1);
    send_byte(sub, a2);
    send_byte(d, a3);
    bus_stop();
    wt(4);
  endtask

  task automatic rd_txn(input logic [7:0] sub, output bit aw, output bit ar, output logic [7:0] d);
    bit as;
    d = 8'h00;
    bus_start();
    send_byte({DEV, 1'b0}, aw);
    send_byte(sub, as);
    bus_rstart();
    send_byte({DEV, 1'b1}, ar);
    if (ar) recv_byte(d);
    bus_stop();
    wt(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    finish_up();
  end

  initial begin
    bit a1, a2, a3, aw, ar;
    logic [7:0] d;
    int n0;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) lmod[i] = 8'h00;
    wt(10); rst_n = 1; wt(5);

    chk("R1 sda released", sda_oe, 0);
    chk("R1 no request", px_req_valid, 0);
    rd_txn(8'h80, aw, ar, d);
    chk("R1 reset reg", d, 8'h00);

    // R2 / R3 local write then read
    n0 = n_req;
    wr_txn(DEV, 8'h85, 8'hC3, a1, a2, a3);
    chk("R2 acks", {a1, a2, a3}, 3'b111);
    lmod[5] = 8'hC3;
    chk("R5 local no request", n_req, n0);
    rd_txn(8'h85, aw, ar, d);
    chk("R3 ack", ar, 1);
    chk("R3 data", d, 8'hC3);
    chk("R3 released", sda_oe, 0);

    // R10 empty range
    wr_txn(DEV, 8'(8'h80 + NREG), 8'h5A, a1, a2, a3);
    chk("R10 acks", {a1, a2, a3}, 3'b111);
    rd_txn(8'(8'h80 + NREG), aw, ar, d);
    chk("R10 read zero", d, 8'h00);
    rd_txn(8'h80, aw, ar, d);
    chk("R10 no alias", d, 8'h00);

    // R4 address mismatch
    n0 = n_req;
    wr_txn(DEV ^ 7'h01, 8'h85, 8'h11, a1, a2, a3);
    chk("R4 no ack", {a1, a2, a3}, 3'b000);
    wr_txn(DEV ^ 7'h40, 8'h05, 8'h22, a1, a2, a3);
    chk("R4 no ack proxy", a1, 0);
    chk("R4 no request", n_req, n0);
    rd_txn(8'h85, aw, ar, d);
    chk("R4 reg kept", d, 8'hC3);

    // R5 / R6 fast downstream write
    px_lat = 1;
    n0 = n_req;
    wr_txn(DEV, 8'h12, 8'h9D, a1, a2, a3);
    chk("R6 fast ack", {a1, a2, a3}, 3'b111);
    chk("R5 one request", n_req, n0 + 1);
    chk("R5 fields", {last_w, last_a, last_d}, {1'b1, 7'h12, 8'h9D});

    // R6 slow downstream write
    px_lat = 60;
    wr_txn(DEV, 8'h13, 8'h44, a1, a2, a3);
    chk("R6 slow nack", {a1, a2, a3}, 3'b110);
    wt(100);
    chk("R6 write landed", pmem[7'h13], 8'h44);

    // R7 / R8 slow fetch with retry
    px_lat = 1500;
    n0 = n_req;
    rd_txn(8'h13, aw, ar, d);
    chk("R7 first ack", ar, 1);
    chk("R7 fetch posted", n_req, n0 + 1);
    chk("R7 fetch fields", {last_w, last_a}, {1'b0, 7'h13});
    rd_txn(8'h13, aw, ar, d);
    chk("R8 pending nack", ar, 0);
    wt(1600);
    rd_txn(8'h13, aw, ar, d);
    chk("R8 retry ack", ar, 1);
    chk("R8 fetched data", d, 8'h44);
    px_lat = 3;
    n0 = n_req;
    rd_txn(8'h13, aw, ar, d);
    chk("R8 consumed refetch", n_req, n0 + 1);
    wt(50);
    rd_txn(8'h13, aw, ar, d);
    chk("R8 second value", d, 8'h44);

    // R9 aborts mid-byte
    n0 = n_req;
    bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h85, a2);
    send_bits(8'h00, 4); bus_stop(); wt(4);
    rd_txn(8'h85, aw, ar, d);
    chk("R9 local kept", d, 8'hC3);
    bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h20, a2);
    send_bits(8'h00, 5); bus_start(); bus_stop(); wt(20);
    chk("R9 no request", n_req, n0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int k = int'($urandom % 4);
      logic [7:0] s, v;
      v = 8'($urandom);
      case (k)
        0: begin
          s = 8'(8'h80 + ($urandom % 20));
          wr_txn(DEV, s, v, a1, a2, a3);
          chk("R2 rnd acks", {a1, a2, a3}, 3'b111);
          if (int'(s[6:0]) < NREG) lmod[s[6:0]] = v;
        end
        1: begin
          s = 8'(8'h80 + ($urandom % 20));
          rd_txn(s, aw, ar, d);
          chk("R3 rnd data", d, exp_loc(s));
        end
        2: begin
          s = {1'b0, 7'($urandom)};
          n0 = n_req;
          wr_txn(DEV, s, v, a1, a2, a3);
          chk("R6 rnd ack", a3, 1);
          chk("R5 rnd fields", {n_req - n0, last_w, last_a, last_d}, {32'd1, 1'b1, s[6:0], v});
          wt(20);
        end
        default: begin
          s = {1'b0, 7'($urandom)};
          rdy_rand = 1;
          px_lat = 1 + int'($urandom % 20);
          rd_txn(s, aw, ar, d);
          chk("R7 rnd first ack", ar, 1);
          ar = 0;
          for (int r = 0; r < 5 && !ar; r++) rd_txn(s, aw, ar, d);
          chk("R8 rnd data", d, pmem[s[6:0]]);
          rdy_rand = 0;
          px_lat = 3;
        end
      endcase
    end
    chk("R11 idle released", sda_oe, 0);
    finish_up();
  end
endmodule